// File: doc/BRIEF.md
# Analog Acquisition Sequencer

This peripheral sits on a processor bus and pulls samples from an external multichannel analog input card without software help in the data path. Software sees four 32-bit words: a control/status word, two words that drive analog output channels, and a scratch word. Setting the run bit in the control word starts the sequencer. It first prepares the card's control-register and read-buffer addresses. It then writes a conversion trigger to the card and reads one word per active channel. Each word that is read comes out as a sample strobe that carries a channel index.

The card is reached through a simple master port. A transfer completes on the cycle in which request and acknowledge are both high. The number of active channels comes from an input that is captured each time a trigger is accepted. When software clears the run bit, the sweep in progress always runs to the end; the sequencer then goes back to idle instead of triggering again.

Top module: `acq_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it rises, the run bit and the output/scratch words are zero, the sequencer is idle, `mst_req` is low and `smp_valid` is low.
- R2: Reading byte offset 0x0 returns `debug_sw` in bits 7:0, the run bit in bit 8 and zero in bits 31:9. A write to 0x0 changes only bit 8.
- R3: Offsets 0x4, 0x8 and 0xC are 32-bit read/write words. The words at 0x4 and 0x8 are driven on `aout_ch1` and `aout_ch2`.
- R4: While the run bit is 0 and the sequencer is idle, no master request is raised.
- R5: After the run bit is set, a trigger is issued: a write (`mst_wr`=1) to `CARD_BASE+BCR_OFS` (default 0x2000_0000) with data `TRIG_WORD` (default 0x0000_0001). The request, address and direction are held until acknowledged.
- R6: After the trigger is acknowledged, N reads (`mst_wr`=0) from `CARD_BASE+RDBUF_OFS` (default 0x2000_0040) follow. N is `chan_count` sampled at trigger acceptance: 0 counts as 1, and values above 8 count as 8.
- R7: The cycle after each read is acknowledged, `smp_valid` is high for one cycle. `smp_chan` counts 0..N-1 in order within a sweep, and `smp_data` is bits 15:0 of `mst_rdata`.
- R8: After the last read of a sweep, a new trigger follows if the run bit is 1. Otherwise the sequencer returns to idle.
- R9: Clearing the run bit during a sweep does not shorten it. All N reads still take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slv_wr | input | 1 | Register write strobe |
| slv_addr | input | 4 | Register byte offset |
| slv_wdata | input | 32 | Register write data |
| slv_rdata | output | 32 | Register read data for `slv_addr` |
| debug_sw | input | 8 | Debug switch levels shown in the control word |
| chan_count | input | 4 | Number of active card channels |
| mst_req | output | 1 | Master transfer request |
| mst_wr | output | 1 | 1 = write (trigger), 0 = read (sample) |
| mst_addr | output | 32 | Card address of the transfer |
| mst_wdata | output | 32 | Write data of the transfer |
| mst_ack | input | 1 | Card completes the current transfer |
| mst_rdata | input | 32 | Read data, valid with `mst_ack` |
| aout_ch1 | output | 32 | Word for analog output channel 1 |
| aout_ch2 | output | 32 | Word for analog output channel 2 |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_chan | output | 3 | Channel index of the sample |
| smp_data | output | 16 | Sample value |

## Verification
The assertions assume that the card raises `mst_ack` only while `mst_req` is high, and for one cycle per transfer. The bench's card model follows this rule: it acknowledges only a pending request, after a programmable delay, and drops the acknowledge on the next cycle. Because of that drop, two read acknowledges are never adjacent, and the one-cycle shape of the sample strobe can be seen. Register writes and `chan_count` changes happen only between sweeps or at known points. Where the run bit is cleared mid-sweep, this is done on purpose and with slow acknowledges, so that the stop lands well inside the sweep.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_TRIG  = 2'd2,
    ST_READ  = 2'd3
  } seq_state_t;

  localparam int REG_CTRL    = 0;
  localparam int REG_AOUT1   = 1;
  localparam int REG_AOUT2   = 2;
  localparam int REG_SCRATCH = 3;
  localparam int NUM_REGS    = 4;
endpackage

// File: rtl/acq_regfile.sv
module acq_regfile #(
  parameter int DATA_W = 32,
  parameter int SW_W   = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SW_W-1:0]   debug_sw,
  output logic [DATA_W-1:0] rdata,
  output logic              run,
  output logic [DATA_W-1:0] aout1,
  output logic [DATA_W-1:0] aout2
);
  import acq_pkg::*;

  localparam int SEL_W   = $clog2(NUM_REGS);
  localparam int RUN_BIT = SW_W;
  localparam int RSV_W   = DATA_W - SW_W - 1;

  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] word_q [NUM_REGS];
  logic              run_q;
  logic              run_en;
  logic [1:0]        unused_lo;

  assign sel       = addr[2 +: SEL_W];
  assign unused_lo = addr[1:0];

  assign run_en = wr_en && (sel == SEL_W'(REG_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (run_en) run_q <= wdata[RUN_BIT];
  end

  assign word_q[REG_CTRL] = {{RSV_W{1'b0}}, run_q, debug_sw};

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_word
    logic              we;
    logic [DATA_W-1:0] q;
    assign we = wr_en && (sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
    end
    assign word_q[g] = q;
  end

  assign rdata = word_q[sel];
  assign run   = run_q;
  assign aout1 = word_q[REG_AOUT1];
  assign aout2 = word_q[REG_AOUT2];

  AST_AOUT1_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_W'(REG_AOUT1)) |=> (aout1 == $past(wdata))); // R3

  AST_CTRL_WRITE_KEEPS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_W'(REG_CTRL)) |=> ($stable(aout1) && $stable(aout2))); // R2

  AST_RUN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_W'(REG_CTRL)) |=> $stable(run)); // R2
endmodule

// File: rtl/acq_chan_ctr.sv
module acq_chan_ctr #(
  parameter int MAX_CH = 8,
  parameter int CH_W   = $clog2(MAX_CH),
  parameter int CNT_W  = CH_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             step,
  output logic [CH_W-1:0]  idx,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_clamped;
  logic [CH_W-1:0]  idx_q, idx_d;

  always_comb begin
    if (cnt_in == '0)                   cnt_clamped = CNT_W'(1);
    else if (cnt_in > CNT_W'(MAX_CH))   cnt_clamped = CNT_W'(MAX_CH);
    else                                cnt_clamped = cnt_in;
  end

  always_comb begin
    idx_d = idx_q;
    if (load)      idx_d = '0;
    else if (step) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= CNT_W'(1);
    else if (load) cnt_q <= cnt_clamped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            idx_q <= '0;
    else if (load || step) idx_q <= idx_d;
  end

  assign idx  = idx_q;
  assign last = ({1'b0, idx_q} == (cnt_q - 1'b1));

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, idx_q} < cnt_q)); // R6

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && (cnt_q <= CNT_W'(MAX_CH))); // R6
endmodule

// File: rtl/acq_master_fsm.sv
module acq_master_fsm #(
  parameter int          DATA_W    = 32,
  parameter int          SMP_W     = 16,
  parameter int          CH_W      = 3,
  parameter logic [31:0] CARD_BASE = 32'h2000_0000,
  parameter logic [31:0] BCR_OFS   = 32'h0000_0000,
  parameter logic [31:0] RDBUF_OFS = 32'h0000_0040,
  parameter logic [31:0] TRIG_WORD = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              mst_ack,
  input  logic [DATA_W-1:0] mst_rdata,
  input  logic [CH_W-1:0]   idx,
  input  logic              last,
  output logic              mst_req,
  output logic              mst_wr,
  output logic [DATA_W-1:0] mst_addr,
  output logic [DATA_W-1:0] mst_wdata,
  output logic              cnt_load,
  output logic              cnt_step,
  output logic              smp_valid,
  output logic [CH_W-1:0]   smp_chan,
  output logic [SMP_W-1:0]  smp_data
);
  import acq_pkg::*;

  seq_state_t        state_q, state_d;
  logic [DATA_W-1:0] bcr_addr_q, buf_addr_q;
  logic              addr_en;
  logic              rd_done;
  logic              smp_valid_q;
  logic [CH_W-1:0]   smp_chan_q;
  logic [SMP_W-1:0]  smp_data_q;
  logic [DATA_W-SMP_W-1:0] unused_hi;

  assign unused_hi = mst_rdata[DATA_W-1:SMP_W];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (run) state_d = ST_SETUP;
      ST_SETUP: state_d = ST_TRIG;
      ST_TRIG:  if (mst_ack) state_d = ST_READ;
      ST_READ:  if (mst_ack && last) state_d = run ? ST_TRIG : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign addr_en = (state_q == ST_SETUP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcr_addr_q <= '0;
      buf_addr_q <= '0;
    end else if (addr_en) begin
      bcr_addr_q <= DATA_W'(CARD_BASE + BCR_OFS);
      buf_addr_q <= DATA_W'(CARD_BASE + RDBUF_OFS);
    end
  end

  assign mst_req   = (state_q == ST_TRIG) || (state_q == ST_READ);
  assign mst_wr    = (state_q == ST_TRIG);
  assign mst_addr  = mst_wr ? bcr_addr_q : buf_addr_q;
  assign mst_wdata = mst_wr ? DATA_W'(TRIG_WORD) : '0;

  assign rd_done  = (state_q == ST_READ) && mst_ack;
  assign cnt_load = (state_q == ST_TRIG) && mst_ack;
  assign cnt_step = rd_done && !last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_valid_q <= 1'b0;
    else        smp_valid_q <= rd_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_chan_q <= '0;
      smp_data_q <= '0;
    end else if (rd_done) begin
      smp_chan_q <= idx;
      smp_data_q <= mst_rdata[SMP_W-1:0];
    end
  end

  assign smp_valid = smp_valid_q;
  assign smp_chan  = smp_chan_q;
  assign smp_data  = smp_data_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !mst_req); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && !mst_ack) |=> (mst_req && $stable(mst_addr) && $stable(mst_wr))); // R5

  AST_SAMPLE_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> smp_valid); // R7

  AST_NO_SAMPLE_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> !smp_valid); // R7

  AST_SWEEP_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && !(mst_ack && last)) |=> (state_q == ST_READ)); // R9

  AST_RETRIGGER_ON_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && last && run) |=> (state_q == ST_TRIG)); // R8
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
  parameter int          DATA_W    = 32,
  parameter int          SW_W      = 8,
  parameter int          ADDR_W    = 4,
  parameter int          MAX_CH    = 8,
  parameter int          SMP_W     = 16,
  parameter logic [31:0] CARD_BASE = 32'h2000_0000,
  parameter logic [31:0] BCR_OFS   = 32'h0000_0000,
  parameter logic [31:0] RDBUF_OFS = 32'h0000_0040,
  parameter logic [31:0] TRIG_WORD = 32'h0000_0001
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      slv_wr,
  input  logic [ADDR_W-1:0]         slv_addr,
  input  logic [DATA_W-1:0]         slv_wdata,
  output logic [DATA_W-1:0]         slv_rdata,
  input  logic [SW_W-1:0]           debug_sw,
  input  logic [$clog2(MAX_CH):0]   chan_count,
  output logic                      mst_req,
  output logic                      mst_wr,
  output logic [DATA_W-1:0]         mst_addr,
  output logic [DATA_W-1:0]         mst_wdata,
  input  logic                      mst_ack,
  input  logic [DATA_W-1:0]         mst_rdata,
  output logic [DATA_W-1:0]         aout_ch1,
  output logic [DATA_W-1:0]         aout_ch2,
  output logic                      smp_valid,
  output logic [$clog2(MAX_CH)-1:0] smp_chan,
  output logic [SMP_W-1:0]          smp_data
);
  localparam int CH_W  = $clog2(MAX_CH);
  localparam int CNT_W = CH_W + 1;

  logic            run;
  logic            cnt_load, cnt_step, last;
  logic [CH_W-1:0] idx;

  acq_regfile #(.DATA_W(DATA_W), .SW_W(SW_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(slv_wr), .addr(slv_addr),
    .wdata(slv_wdata), .debug_sw(debug_sw), .rdata(slv_rdata),
    .run(run), .aout1(aout_ch1), .aout2(aout_ch2)
  );

  acq_chan_ctr #(.MAX_CH(MAX_CH), .CH_W(CH_W), .CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .cnt_in(chan_count),
    .step(cnt_step), .idx(idx), .last(last)
  );

  acq_master_fsm #(
    .DATA_W(DATA_W), .SMP_W(SMP_W), .CH_W(CH_W), .CARD_BASE(CARD_BASE),
    .BCR_OFS(BCR_OFS), .RDBUF_OFS(RDBUF_OFS), .TRIG_WORD(TRIG_WORD)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .run(run), .mst_ack(mst_ack),
    .mst_rdata(mst_rdata), .idx(idx), .last(last), .mst_req(mst_req),
    .mst_wr(mst_wr), .mst_addr(mst_addr), .mst_wdata(mst_wdata),
    .cnt_load(cnt_load), .cnt_step(cnt_step), .smp_valid(smp_valid),
    .smp_chan(smp_chan), .smp_data(smp_data)
  );

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mst_ack |-> mst_req); // R5

  AST_STOPPED_STAYS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst_req && !run) |=> !mst_req); // R4
endmodule

// File: tb/tb_acq_sequencer.sv
`timescale 1ns/1ps
module tb_acq_sequencer;
  localparam logic [31:0] BCR_ADDR = 32'h2000_0000;
  localparam logic [31:0] BUF_ADDR = 32'h2000_0040;
  localparam logic [31:0] TRIG     = 32'h0000_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slv_wr = 1'b0;
  logic [3:0]  slv_addr = '0;
  logic [31:0] slv_wdata = '0;
  logic [31:0] slv_rdata;
  logic [7:0]  debug_sw = 8'h5A;
  logic [3:0]  chan_count = 4'd3;
  logic        mst_req, mst_wr;
  logic [31:0] mst_addr, mst_wdata;
  logic        mst_ack = 1'b0;
  logic [31:0] mst_rdata = '0;
  logic [31:0] aout_ch1, aout_ch2;
  logic        smp_valid;
  logic [2:0]  smp_chan;
  logic [15:0] smp_data;

  int checks = 0, errors = 0;
  int ack_delay = 1, wait_cnt = 0;
  int trig_seen = 0, reads = 0, exp_len = 3, samples = 0;
  logic [2:0]  exp_chan = '0;
  logic [15:0] exp_data = '0;
  logic        prev_valid = 1'b0;

  always #2.5 clk = ~clk;

  acq_sequencer dut (
    .clk(clk), .rst_n(rst_n), .slv_wr(slv_wr), .slv_addr(slv_addr),
    .slv_wdata(slv_wdata), .slv_rdata(slv_rdata), .debug_sw(debug_sw),
    .chan_count(chan_count), .mst_req(mst_req), .mst_wr(mst_wr),
    .mst_addr(mst_addr), .mst_wdata(mst_wdata), .mst_ack(mst_ack),
    .mst_rdata(mst_rdata), .aout_ch1(aout_ch1), .aout_ch2(aout_ch2),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Card model: acknowledges a pending request after ack_delay cycles
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mst_ack  = 1'b0;
        wait_cnt = 0;
      end else if (mst_ack) begin
        mst_ack = 1'b0;
      end else if (mst_req) begin
        if (wait_cnt < ack_delay) wait_cnt++;
        else begin
          wait_cnt = 0;
          mst_ack  = 1'b1;
          if (mst_wr) begin
            chk(mst_addr == BCR_ADDR, "R5 trigger address", mst_addr, BCR_ADDR);
            chk(mst_wdata == TRIG, "R5 trigger word", mst_wdata, TRIG);
            if (trig_seen > 0)
              chk(reads == exp_len, "R6 sweep length", reads, exp_len);
            trig_seen++;
            reads = 0;
          end else begin
            chk(mst_addr == BUF_ADDR, "R6 read address", mst_addr, BUF_ADDR);
            exp_chan  = 3'(reads);
            exp_data  = 16'(trig_seen * 32 + reads);
            mst_rdata = {16'hBEEF, exp_data};
            reads++;
          end
        end
      end
    end
  end

  // Sample monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && smp_valid) begin
        samples++;
        chk(!prev_valid, "R7 strobe one cycle", 32'(prev_valid), 0);
        chk(smp_chan == exp_chan, "R7 channel index", 32'(smp_chan), 32'(exp_chan));
        chk(smp_data == exp_data, "R7 sample low half", 32'(smp_data), 32'(exp_data));
      end
      prev_valid = smp_valid;
    end
  end

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    slv_wr = 1'b1; slv_addr = a; slv_wdata = d;
    @(negedge clk);
    slv_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    slv_addr = a;
    #0.5;
    d = slv_rdata;
  endtask

  task automatic clear_tracking();
    trig_seen = 0; reads = 0; samples = 0;
  endtask

  task automatic test_reset();
    logic [31:0] d;
    chk(mst_req == 1'b0 && smp_valid == 1'b0, "R1 outputs in reset",
        {mst_req, smp_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    reg_read(4'h0, d); chk(d == 32'h0000_005A, "R1 ctrl after reset", d, 32'h5A);
    reg_read(4'hC, d); chk(d == 32'h0, "R1 scratch after reset", d, 0);
    chk(aout_ch1 == 0 && aout_ch2 == 0, "R1 outputs words zero", aout_ch1 | aout_ch2, 0);
  endtask

  task automatic test_regs();
    logic [31:0] d;
    reg_write(4'h4, 32'h1234_5678);
    reg_write(4'h8, 32'h9ABC_DEF0);
    reg_write(4'hC, 32'h0F0F_A5A5);
    reg_read(4'h4, d); chk(d == 32'h1234_5678, "R3 word 0x4", d, 32'h1234_5678);
    reg_read(4'h8, d); chk(d == 32'h9ABC_DEF0, "R3 word 0x8", d, 32'h9ABC_DEF0);
    reg_read(4'hC, d); chk(d == 32'h0F0F_A5A5, "R3 word 0xC", d, 32'h0F0F_A5A5);
    chk(aout_ch1 == 32'h1234_5678, "R3 aout_ch1", aout_ch1, 32'h1234_5678);
    chk(aout_ch2 == 32'h9ABC_DEF0, "R3 aout_ch2", aout_ch2, 32'h9ABC_DEF0);
    reg_write(4'h0, 32'hFFFF_FEFF);
    debug_sw = 8'hC3;
    reg_read(4'h0, d); chk(d == 32'h0000_00C3, "R2 ctrl readback", d, 32'hC3);
    reg_read(4'h4, d); chk(d == 32'h1234_5678, "R2 ctrl write leaves 0x4", d, 32'h1234_5678);
  endtask

  task automatic test_idle();
    clear_tracking();
    repeat (20) @(negedge clk);
    chk(mst_req == 1'b0 && trig_seen == 0, "R4 no request while stopped",
        32'(trig_seen), 0);
  endtask

  task automatic test_sweeps(input logic [3:0] cnt, input int exp, input int dly);
    logic [31:0] d;
    clear_tracking();
    chan_count = cnt; exp_len = exp; ack_delay = dly;
    reg_write(4'h0, 32'h0000_0100);
    reg_read(4'h0, d); chk(d[8] == 1'b1, "R2 run bit reads back", 32'(d[8]), 1);
    wait (trig_seen == 3);
    reg_write(4'h0, 32'h0);
    repeat (120) @(negedge clk);
    chk(trig_seen == 3, "R8 stop after sweep", trig_seen, 3);
    chk(reads == exp, "R6 final sweep length", reads, exp);
    chk(samples == 3 * exp, "R7 sample count", samples, 3 * exp);
    chk(mst_req == 1'b0, "R8 idle after stop", 32'(mst_req), 0);
  endtask

  task automatic test_stop_mid();
    clear_tracking();
    chan_count = 4'd8; exp_len = 8; ack_delay = 3;
    reg_write(4'h0, 32'h0000_0100);
    wait (trig_seen == 1 && reads == 1);
    reg_write(4'h0, 32'h0);
    repeat (120) @(negedge clk);
    chk(reads == 8, "R9 sweep completes", reads, 8);
    chk(trig_seen == 1, "R9 no retrigger", trig_seen, 1);
    chk(samples == 8, "R9 samples delivered", samples, 8);
  endtask

  task automatic test_reset_mid();
    logic [31:0] d;
    clear_tracking();
    chan_count = 4'd4; exp_len = 4; ack_delay = 2;
    reg_write(4'hC, 32'hDEAD_0001);
    reg_write(4'h0, 32'h0000_0100);
    wait (trig_seen == 1);
    @(negedge clk); rst_n = 1'b0;
    #0.5;
    chk(mst_req == 1'b0 && smp_valid == 1'b0, "R1 async reset quiets port",
        {mst_req, smp_valid}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    clear_tracking();
    reg_read(4'h0, d); chk(d == 32'h0000_00C3, "R1 run cleared", d, 32'hC3);
    reg_read(4'hC, d); chk(d == 32'h0, "R1 scratch cleared", d, 0);
    repeat (20) @(negedge clk);
    chk(trig_seen == 0 && mst_req == 1'b0, "R1 idle after reset", 32'(trig_seen), 0);
  endtask

  initial begin
    test_reset();
    test_regs();
    test_idle();
    test_sweeps(4'd3, 3, 1);
    test_sweeps(4'd0, 1, 0);
    test_sweeps(4'd12, 8, 1);
    test_stop_mid();
    test_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule